// File: doc/BRIEF.md
# CAN Bit-Stuffing Codec

This block sits in the serial path of a CAN controller and handles bit stuffing in both directions. In transmit mode it takes one bit per bit-time strobe from the frame builder. The builder also supplies a flag that marks whether the bit belongs to a stuffable field. Once the stuffable stream has carried five bits of equal level, the block places a bit of the opposite level on its output. During that slot it withholds its ready signal, so the offered bit stays pending until the next strobe.

In receive mode the same run tracker follows the sampled bus bits. The bit that follows five equal bits is treated as a stuff bit and removed from the output. If that bit has the same level as the run, the block raises a stuff error. Level 0 is dominant and level 1 is recessive. The block only counts levels and never inverts them.

A stuff bit starts a new run of length one. The run count clears whenever a bit flagged as fixed-form passes, so a delimiter, the ACK field, the EOF and error or overload flags go through unchanged.

Top module: `can_bitstuff`

## Requirements
- R1: In transmit mode, after five consecutive equal bits counted in the stuffable stream, the next emitted bit has the opposite level and `out_stuff` is 1 for that bit.
- R2: During a transmit stuff slot, `in_ready` is 0 and the offered bit is not consumed. That bit is emitted at the following strobe.
- R3: A bit offered with `in_stuffable`=0 clears the run count. A stream of such bits is never stuffed, however long its runs are.
- R4: An inserted stuff bit counts as the first bit of a new run. After a stuff bit of level 1, four more 1s trigger a stuff bit of level 0.
- R5: A stuff bit that falls due after the last stuffable bit is still inserted when the next offered bit is flagged fixed-form.
- R6: In receive mode `in_ready` is always 1. The bit following five equal bits is dropped: `out_valid` stays 0 and `out_stuff` is 1 for that strobe.
- R7: In receive mode `stuff_err` pulses for one cycle when the dropped bit has the same level as the run. It stays 0 when the dropped bit has the opposite level.
- R8: Outputs are registered. `out_valid`, `out_stuff` and `stuff_err` pulse for exactly the clock cycle after a strobe and are 0 in cycles without a strobe.
- R9: While reset is held, `out_valid`=0, `stuff_err`=0, `out_stuff`=0 and `in_ready`=1.
- R10: In receive mode, the bits that follow a dropped stuff bit are counted with the stuff bit as the first bit of the run, the same as in transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-time strobe, one cycle per bit |
| mode_rx | input | 1 | 0 = stuff (transmit), 1 = destuff (receive) |
| in_bit | input | 1 | Offered bit (0 dominant, 1 recessive) |
| in_stuffable | input | 1 | Offered bit belongs to a stuffable field |
| in_ready | output | 1 | Offered bit is consumed at this strobe |
| out_bit | output | 1 | Emitted bit level |
| out_valid | output | 1 | Pulse: `out_bit` carries a new bit |
| out_stuff | output | 1 | Pulse: this strobe was a stuff slot |
| stuff_err | output | 1 | Pulse: receive stuff bit had the run's level |

## Verification
Two functions can fall in the same bit slot. The first is a stuff slot coming due. The second is the arrival of a bit flagged fixed-form, which clears the run. The bench provokes this by ending a five-bit stuffable run and offering the delimiter at the next strobe. It then checks that the stuff bit appears first with ready low, and that the held delimiter follows with no further stuffing. In receive mode a dropped stuff bit coincides with an error decision. Runs ending in both a valid and an invalid stuff level show that the drop and the error pulse are judged together.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;

  // Run length after a consumed, non-stuff bit. A fixed-form bit clears the run.
  function automatic int run_next_count(int cnt, logic lvl, logic b, logic stf, int lim);
    int r;
    if (!stf)             r = 0;
    else if (cnt == 0)    r = 1;
    else if (b != lvl)    r = 1;
    else if (cnt >= lim)  r = lim;
    else                  r = cnt + 1;
    return r;
  endfunction

  // Level a transmit stuff bit carries: opposite of the run.
  function automatic logic stuff_level(logic lvl);
    return ~lvl;
  endfunction

endpackage

// File: rtl/can_run_tracker.sv
module can_run_tracker #(
  parameter int RUN_LEN = 5,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             slot,
  input  logic             mode_rx,
  input  logic             in_bit,
  input  logic             in_stuffable,
  output logic [CNT_W-1:0] run_cnt,
  output logic             run_lvl
);
  import can_stuff_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      run_lvl <= 1'b1;
    end else if (step) begin
      if (slot) begin
        run_cnt <= CNT_W'(1);
        run_lvl <= mode_rx ? in_bit : stuff_level(run_lvl);
      end else begin
        run_cnt <= CNT_W'(run_next_count(int'(run_cnt), run_lvl, in_bit, in_stuffable, RUN_LEN));
        run_lvl <= in_bit;
      end
    end
  end

  // R1
  run_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_cnt) <= RUN_LEN);

endmodule

// File: rtl/can_stuff_decide.sv
module can_stuff_decide #(
  parameter int RUN_LEN = 5,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_rx,
  input  logic             in_bit,
  input  logic [CNT_W-1:0] run_cnt,
  input  logic             run_lvl,
  output logic             slot,
  output logic             ready,
  output logic             drop,
  output logic             err
);
  always_comb begin
    slot  = (int'(run_cnt) == RUN_LEN);
    ready = mode_rx || !slot;
    drop  = mode_rx && slot;
    err   = drop && (in_bit == run_lvl);
  end

  // R6
  ready_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rx |-> ready);

endmodule

// File: rtl/can_out_stage.sv
module can_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic mode_rx,
  input  logic slot,
  input  logic drop,
  input  logic err,
  input  logic in_bit,
  input  logic stuff_bit,
  output logic out_bit,
  output logic out_valid,
  output logic out_stuff,
  output logic stuff_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_bit   <= 1'b1;
      out_valid <= 1'b0;
      out_stuff <= 1'b0;
      stuff_err <= 1'b0;
    end else if (step) begin
      out_valid <= !drop;
      out_stuff <= slot;
      stuff_err <= err;
      if (!mode_rx && slot) out_bit <= stuff_bit;
      else if (!drop)       out_bit <= in_bit;
    end else begin
      out_valid <= 1'b0;
      out_stuff <= 1'b0;
      stuff_err <= 1'b0;
    end
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> (!out_valid && !out_stuff && !stuff_err));

endmodule

// File: rtl/can_bitstuff.sv
module can_bitstuff #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic mode_rx,
  input  logic in_bit,
  input  logic in_stuffable,
  output logic in_ready,
  output logic out_bit,
  output logic out_valid,
  output logic out_stuff,
  output logic stuff_err
);
  import can_stuff_pkg::*;
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] run_cnt;
  logic             run_lvl;
  logic             slot_w, drop_w, err_w, stuff_bit_w;

  assign stuff_bit_w = stuff_level(run_lvl);

  can_run_tracker #(.RUN_LEN(RUN_LEN)) u_track (
    .clk(clk), .rst_n(rst_n), .step(bit_en), .slot(slot_w), .mode_rx(mode_rx),
    .in_bit(in_bit), .in_stuffable(in_stuffable), .run_cnt(run_cnt), .run_lvl(run_lvl));

  can_stuff_decide #(.RUN_LEN(RUN_LEN)) u_decide (
    .clk(clk), .rst_n(rst_n), .mode_rx(mode_rx), .in_bit(in_bit), .run_cnt(run_cnt),
    .run_lvl(run_lvl), .slot(slot_w), .ready(in_ready), .drop(drop_w), .err(err_w));

  can_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .step(bit_en), .mode_rx(mode_rx), .slot(slot_w),
    .drop(drop_w), .err(err_w), .in_bit(in_bit), .stuff_bit(stuff_bit_w),
    .out_bit(out_bit), .out_valid(out_valid), .out_stuff(out_stuff), .stuff_err(stuff_err));

  // R1
  stuff_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slot_w && !mode_rx) |=> (out_stuff && out_valid && out_bit != $past(run_lvl)));

  // R3
  fixed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !slot_w && !in_stuffable) |=> (run_cnt == '0));

  // R2
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rx && slot_w) |-> !in_ready);

  // R6
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && drop_w) |=> !out_valid);

  // R7
  rx_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mode_rx && slot_w && in_bit == run_lvl) |=> stuff_err);

endmodule

// File: tb/can_bitstuff_test.sv
module can_bitstuff_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, mode_rx = 1'b0, in_bit = 1'b1, in_stuffable = 1'b0;
  logic in_ready, out_bit, out_valid, out_stuff, stuff_err;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  can_bitstuff uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode_rx(mode_rx), .in_bit(in_bit),
    .in_stuffable(in_stuffable), .in_ready(in_ready), .out_bit(out_bit),
    .out_valid(out_valid), .out_stuff(out_stuff), .stuff_err(stuff_err));

  // Vector bits: [7]rx [6]in [5]stuffable [4]exp_ready [3]exp_valid [2]exp_out [1]exp_stuff [0]exp_err
  localparam int NV = 34;
  localparam logic [7:0] VEC [NV] = '{
    8'b00111000, 8'b00111000, 8'b00111000, 8'b00111000, 8'b00111000, // R1 five zeros
    8'b01101110,                                                     // R2 stuff 1, offered 1 held
    8'b01111100, 8'b01111100, 8'b01111100, 8'b01111100,              // R4 stuff + four 1s
    8'b00101010,                                                     // R4 stuff 0
    8'b00111000, 8'b00111000, 8'b00111000, 8'b00111000,              // R5 run of zeros
    8'b01001110,                                                     // R5 stuff before fixed-form bit
    8'b01011100, 8'b01011100, 8'b01011100, 8'b01011100, 8'b01011100, 8'b01011100, // R3
    8'b10111000, 8'b10111000, 8'b10111000, 8'b10111000, 8'b10111000, // R10 rx zeros
    8'b11110010,                                                     // R6 drop valid stuff
    8'b11111100, 8'b11111100, 8'b11111100, 8'b11111100,              // R10 stuff bit opens run
    8'b11110011,                                                     // R7 bad stuff level
    8'b10011000                                                      // R3 fixed-form in rx
  };

  function automatic string tag_of(int i);
    if (i < 5)        return "R1";
    else if (i == 5)  return "R2";
    else if (i < 11)  return "R4";
    else if (i < 16)  return "R5";
    else if (i < 22)  return "R3";
    else if (i == 27) return "R6";
    else if (i == 32) return "R7";
    else if (i == 33) return "R3";
    else              return "R10";
  endfunction

  task automatic chk(string tag, string what, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0b exp=%0b", tag, what, got, exp);
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "out_valid", out_valid, 1'b0);
    chk("R9", "stuff_err", stuff_err, 1'b0);
    chk("R9", "out_stuff", out_stuff, 1'b0);
    chk("R9", "in_ready", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 no strobe, nothing emitted
    chk("R8", "idle out_valid", out_valid, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_rx = VEC[i][7];
      in_bit = VEC[i][6];
      in_stuffable = VEC[i][5];
      bit_en = 1'b1;
      #1;
      chk(tag_of(i), $sformatf("vec%0d ready", i), in_ready, VEC[i][4]);
      @(negedge clk);
      bit_en = 1'b0;
      #1;
      chk(tag_of(i), $sformatf("vec%0d valid", i), out_valid, VEC[i][3]);
      if (VEC[i][3]) chk(tag_of(i), $sformatf("vec%0d bit", i), out_bit, VEC[i][2]);
      chk(tag_of(i), $sformatf("vec%0d stuff", i), out_stuff, VEC[i][1]);
      chk(tag_of(i), $sformatf("vec%0d err", i), stuff_err, VEC[i][0]);
      @(negedge clk);
      #1;
      // R8 pulse lasts one cycle
      chk("R8", $sformatf("vec%0d valid drop", i), out_valid, 1'b0);
      chk("R8", $sformatf("vec%0d err drop", i), stuff_err, 1'b0);
    end

    // R9 reset mid-run clears the run: four zeros, reset, five zeros need no stuff
    mode_rx = 1'b0;
    in_stuffable = 1'b1;
    in_bit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0;
    end
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); bit_en = 1'b1; #1;
      chk("R9", $sformatf("post-reset ready %0d", k), in_ready, 1'b1);
      @(negedge clk); bit_en = 1'b0; #1;
      chk("R9", $sformatf("post-reset stuff %0d", k), out_stuff, 1'b0);
    end
    @(negedge clk); #1;
    chk("R1", "sixth slot stuffs", in_ready, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule